// File: doc/BRIEF.md
# Read-Modify-Write Target Sequencer

This block carries out an already authorised read-modify-write command from start to finish. When a command is accepted, the block checks the instruction code and the data length. It then takes the external bus and reads the original word. It hands that word, together with the data and mask carried by the command, to an external modify unit. It waits for that unit to acknowledge with a new word, and writes the new word back over the bus. Finally it emits a reply, one byte per cycle, that carries the word as it was before the modification.

The bus is held for the whole operation, from the first grant until the write has been acknowledged, so no other master can slip in between the read and the write. A command with a wrong instruction code or a wrong length never reaches the bus. It is answered at once with an error reply. Byte order on the bus is chosen by a configuration input, which is sampled when each command is accepted. Header parsing and link serialisation sit outside this block.

Top module: `rmw_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `cmd_ready` is 1 and `bus_req`, `bus_stb`, `mod_req` and `rep_valid` are 0.
- R2: A command accepted (`cmd_valid` high while `cmd_ready` is high) whose instruction code is not 4'b0111 is rejected with status byte 0x02. `bus_req` never rises for it.
- R3: A command with instruction code 4'b0111 whose length field is not 2*WORD_BYTES (8 by default) is rejected with status byte 0x05. `bus_req` never rises for it.
- R4: Payload byte k sits at `cmd_payload[8k+7:8k]`. Bytes 0..WORD_BYTES-1 form the data word and the next WORD_BYTES bytes form the mask word. With `cfg_msb_first`=1, payload byte 0 of each group lands in the most significant byte of the word. With 0 it lands in the least significant byte. `cfg_msb_first` is sampled when the command is accepted.
- R5: The read phase raises `bus_req`. In the cycle after a sampled `bus_gnt`, it raises `bus_stb` with `bus_we`=0 and `bus_addr` equal to the command address. These hold until `bus_ack`, at which point `bus_rdata` is taken as the original word.
- R6: After the read, `mod_req` is high with `mod_orig`, `mod_data` and `mod_mask` held steady until `mod_ack`. `mod_word` is taken as the new word at that point.
- R7: After the modify step, a further sampled `bus_gnt` starts the write. `bus_stb`=1 and `bus_we`=1 with `bus_wdata` equal to the new word, held until `bus_ack`.
- R8: `bus_req` stays high without a gap from the read request until the cycle that samples the write `bus_ack`, and is low in the next cycle.
- R9: A successful command produces a reply of 5+WORD_BYTES+1 bytes, one per cycle with no gap, in this order: status 0x00, length bytes 0x00 0x00 WORD_BYTES, header CRC, the original read word (not the new word) in the byte order of R4, and data CRC. `rep_last` marks the final byte.
- R10: A rejected command produces a 5-byte reply: the status byte, 0x00 0x00 0x00, and the header CRC, with `rep_last` on the CRC byte.
- R11: Each CRC is CRC-8 with generator x^8+x^2+x+1 and a register that starts at 0. Each byte is fed bit 0 first. For each bit, the feedback is register bit 7 XOR the data bit, the register shifts left, and it is XORed with 0x07 when the feedback is 1. The header CRC covers the 4 header bytes and the data CRC covers the data bytes.
- R12: `cmd_ready` returns to 1 in the cycle after the final reply byte, and a new command is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_msb_first | input | 1 | Byte order select, 1 = first byte most significant |
| cmd_valid | input | 1 | Authorised command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_instr | input | 4 | Instruction code field |
| cmd_len | input | LEN_W | Data length field |
| cmd_addr | input | ADDR_W | Target bus address |
| cmd_payload | input | 16*WORD_BYTES | Data bytes followed by mask bytes |
| bus_req | output | 1 | Bus request, held for the whole operation |
| bus_gnt | input | 1 | Bus grant |
| bus_stb | output | 1 | Bus access strobe |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8*WORD_BYTES | Bus write word |
| bus_rdata | input | 8*WORD_BYTES | Bus read word |
| bus_ack | input | 1 | Bus access complete |
| mod_req | output | 1 | Modify request |
| mod_orig | output | 8*WORD_BYTES | Original word read from the bus |
| mod_data | output | 8*WORD_BYTES | Command data word |
| mod_mask | output | 8*WORD_BYTES | Command mask word |
| mod_ack | input | 1 | Modify complete |
| mod_word | input | 8*WORD_BYTES | Modified word returned with the acknowledge |
| rep_valid | output | 1 | Reply byte valid |
| rep_data | output | 8 | Reply byte |
| rep_last | output | 1 | Final reply byte |

## Verification
The bench builds the block with its defaults: WORD_BYTES=4, ADDR_W=32 and LEN_W=24. That gives a 10-byte success reply, a 5-byte error reply and a length of 8 as the only one accepted. These values bring both lengths near the legal one (4 and 16) and every byte-order permutation of a 32-bit word within reach. A grant responder that withdraws the grant during the modify step makes the second grant a real wait, while zero-delay runs cover back-to-back grant and acknowledge. The configuration input is flipped right after acceptance, which shows that the byte order is latched per command.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_RD_GNT = 3'd1,
        SQ_RD_ACC = 3'd2,
        SQ_MODIFY = 3'd3,
        SQ_WR_GNT = 3'd4,
        SQ_WR_ACC = 3'd5,
        SQ_REPLY  = 3'd6
    } seq_state_e;

    localparam logic [3:0] RMW_CODE     = 4'b0111;
    localparam logic [7:0] STS_OK       = 8'h00;
    localparam logic [7:0] STS_BAD_CODE = 8'h02;
    localparam logic [7:0] STS_BAD_LEN  = 8'h05;

    // One byte of CRC-8 (x^8+x^2+x+1), data bit 0 taken first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] r;
        logic       fb;
        r = crc;
        for (int i = 0; i < 8; i++) begin
            fb = r[7] ^ din[i];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

endpackage

// File: rtl/rmw_byte_order.sv
module rmw_byte_order #(
    parameter int WB = 4
) (
    input  logic            msb_first_i,
    input  logic [8*WB-1:0] in_i,
    output logic [8*WB-1:0] out_o
);

    // Lane p takes byte WB-1-p when reversed; the mapping is its own inverse,
    // so one instance packs bytes into a word and another unpacks a word.
    for (genvar p = 0; p < WB; p++) begin : g_lane
        assign out_o[8*p +: 8] = msb_first_i ? in_i[8*(WB-1-p) +: 8] : in_i[8*p +: 8];
    end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24,
    parameter int WB     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_msb_first_i,
    input  logic                cmd_valid_i,
    input  logic [3:0]          cmd_instr_i,
    input  logic [LEN_W-1:0]    cmd_len_i,
    input  logic [ADDR_W-1:0]   cmd_addr_i,
    input  logic [16*WB-1:0]    cmd_payload_i,
    output logic                cmd_ready_o,
    input  logic                bus_gnt_i,
    input  logic                bus_ack_i,
    input  logic [8*WB-1:0]     bus_rdata_i,
    output logic                bus_req_o,
    output logic                bus_stb_o,
    output logic                bus_we_o,
    output logic [ADDR_W-1:0]   bus_addr_o,
    output logic [8*WB-1:0]     bus_wdata_o,
    input  logic                mod_ack_i,
    input  logic [8*WB-1:0]     mod_word_i,
    output logic                mod_req_o,
    output logic [8*WB-1:0]     mod_orig_o,
    output logic [16*WB-1:0]    payload_o,
    output logic                msb_o,
    output logic                rep_start_o,
    output logic [7:0]          status_o,
    output logic                err_o,
    input  logic                rep_done_i
);

    localparam int              WW   = 8 * WB;
    localparam int              PW   = 2 * WW;
    localparam logic [LEN_W-1:0] DLEN = LEN_W'(2 * WB);

    typedef struct packed {
        seq_state_e        st;
        logic              msb;
        logic [7:0]        status;
        logic [ADDR_W-1:0] addr;
        logic [PW-1:0]     payload;
        logic [WW-1:0]     orig;
        logic [WW-1:0]     wr_word;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        rep_start_o = 1'b0;
        unique case (ctl_q.st)
            SQ_IDLE: begin
                if (cmd_valid_i) begin
                    ctl_d.msb     = cfg_msb_first_i;
                    ctl_d.addr    = cmd_addr_i;
                    ctl_d.payload = cmd_payload_i;
                    if (cmd_instr_i != RMW_CODE) begin
                        ctl_d.status = STS_BAD_CODE;
                        ctl_d.st     = SQ_REPLY;
                        rep_start_o  = 1'b1;
                    end else if (cmd_len_i != DLEN) begin
                        ctl_d.status = STS_BAD_LEN;
                        ctl_d.st     = SQ_REPLY;
                        rep_start_o  = 1'b1;
                    end else begin
                        ctl_d.status = STS_OK;
                        ctl_d.st     = SQ_RD_GNT;
                    end
                end
            end
            SQ_RD_GNT: if (bus_gnt_i) ctl_d.st = SQ_RD_ACC;
            SQ_RD_ACC: begin
                if (bus_ack_i) begin
                    ctl_d.orig = bus_rdata_i;
                    ctl_d.st   = SQ_MODIFY;
                end
            end
            SQ_MODIFY: begin
                if (mod_ack_i) begin
                    ctl_d.wr_word = mod_word_i;
                    ctl_d.st      = SQ_WR_GNT;
                end
            end
            SQ_WR_GNT: if (bus_gnt_i) ctl_d.st = SQ_WR_ACC;
            SQ_WR_ACC: begin
                if (bus_ack_i) begin
                    ctl_d.st    = SQ_REPLY;
                    rep_start_o = 1'b1;
                end
            end
            SQ_REPLY: if (rep_done_i) ctl_d.st = SQ_IDLE;
            default:  ctl_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cmd_ready_o = (ctl_q.st == SQ_IDLE);
    assign bus_req_o   = ctl_q.st inside {SQ_RD_GNT, SQ_RD_ACC, SQ_MODIFY, SQ_WR_GNT, SQ_WR_ACC};
    assign bus_stb_o   = (ctl_q.st == SQ_RD_ACC) || (ctl_q.st == SQ_WR_ACC);
    assign bus_we_o    = (ctl_q.st == SQ_WR_ACC);
    assign bus_addr_o  = ctl_q.addr;
    assign bus_wdata_o = ctl_q.wr_word;
    assign mod_req_o   = (ctl_q.st == SQ_MODIFY);
    assign mod_orig_o  = ctl_q.orig;
    assign payload_o   = ctl_q.payload;
    assign msb_o       = ctl_q.msb;
    assign status_o    = ctl_q.status;
    assign err_o       = (ctl_q.status != STS_OK);

    AST_BADCODE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready_o && cmd_valid_i && cmd_instr_i != RMW_CODE) |=> !bus_req_o); // R2
    AST_BADLEN_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready_o && cmd_valid_i && cmd_instr_i == RMW_CODE && cmd_len_i != DLEN) |=> !bus_req_o); // R3
    AST_BUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !(bus_stb_o && bus_we_o && bus_ack_i)) |=> bus_req_o); // R8
    AST_MODIFY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req_o && !mod_ack_i) |=> (mod_req_o && $stable(mod_orig_o))); // R6

endmodule

// File: rtl/rmw_reply_gen.sv
module rmw_reply_gen
    import rmw_pkg::*;
#(
    parameter int WB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            err_i,
    input  logic [7:0]      status_i,
    input  logic [8*WB-1:0] bytes_i,
    output logic            rep_valid_o,
    output logic [7:0]      rep_data_o,
    output logic            rep_last_o
);

    localparam int            IW      = $clog2(WB + 7);
    localparam logic [IW-1:0] IX_LEN  = IW'(3);
    localparam logic [IW-1:0] IX_HCRC = IW'(4);
    localparam logic [IW-1:0] IX_DCRC = IW'(5 + WB);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        logic [7:0]    crc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [7:0] cur_byte;
    logic       last;

    always_comb begin
        cur_byte = 8'h00;
        if (gen_q.idx == '0) begin
            cur_byte = status_i;
        end else if (gen_q.idx == IX_LEN) begin
            cur_byte = err_i ? 8'h00 : 8'(WB);
        end else if (gen_q.idx == IX_HCRC || gen_q.idx == IX_DCRC) begin
            cur_byte = gen_q.crc;
        end
        for (int k = 0; k < WB; k++) begin
            if (gen_q.idx == IW'(5 + k)) cur_byte = bytes_i[8*k +: 8];
        end
        last = gen_q.active && (gen_q.idx == (err_i ? IX_HCRC : IX_DCRC));

        gen_d = gen_q;
        if (start_i) begin
            gen_d.active = 1'b1;
            gen_d.idx    = '0;
            gen_d.crc    = 8'h00;
        end else if (gen_q.active) begin
            gen_d.crc = (gen_q.idx == IX_HCRC) ? 8'h00 : crc8_step(gen_q.crc, cur_byte);
            if (last) gen_d.active = 1'b0;
            else      gen_d.idx    = gen_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign rep_valid_o = gen_q.active;
    assign rep_data_o  = cur_byte;
    assign rep_last_o  = last;

    AST_REPLY_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid_o && !rep_last_o) |=> rep_valid_o); // R9

endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
    import rmw_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_msb_first,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [3:0]              cmd_instr,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [16*WORD_BYTES-1:0] cmd_payload,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic                    bus_stb,
    output logic                    bus_we,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [8*WORD_BYTES-1:0] bus_wdata,
    input  logic [8*WORD_BYTES-1:0] bus_rdata,
    input  logic                    bus_ack,
    output logic                    mod_req,
    output logic [8*WORD_BYTES-1:0] mod_orig,
    output logic [8*WORD_BYTES-1:0] mod_data,
    output logic [8*WORD_BYTES-1:0] mod_mask,
    input  logic                    mod_ack,
    input  logic [8*WORD_BYTES-1:0] mod_word,
    output logic                    rep_valid,
    output logic [7:0]              rep_data,
    output logic                    rep_last
);

    localparam int WW = 8 * WORD_BYTES;
    localparam int PW = 2 * WW;

    logic [PW-1:0] payload;
    logic          msb_lat;
    logic          rep_start;
    logic [7:0]    status;
    logic          err;
    logic          last_w;
    logic [WW-1:0] orig_bytes;

    rmw_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WB(WORD_BYTES)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_msb_first_i (cfg_msb_first),
        .cmd_valid_i     (cmd_valid),
        .cmd_instr_i     (cmd_instr),
        .cmd_len_i       (cmd_len),
        .cmd_addr_i      (cmd_addr),
        .cmd_payload_i   (cmd_payload),
        .cmd_ready_o     (cmd_ready),
        .bus_gnt_i       (bus_gnt),
        .bus_ack_i       (bus_ack),
        .bus_rdata_i     (bus_rdata),
        .bus_req_o       (bus_req),
        .bus_stb_o       (bus_stb),
        .bus_we_o        (bus_we),
        .bus_addr_o      (bus_addr),
        .bus_wdata_o     (bus_wdata),
        .mod_ack_i       (mod_ack),
        .mod_word_i      (mod_word),
        .mod_req_o       (mod_req),
        .mod_orig_o      (mod_orig),
        .payload_o       (payload),
        .msb_o           (msb_lat),
        .rep_start_o     (rep_start),
        .status_o        (status),
        .err_o           (err),
        .rep_done_i      (last_w)
    );

    rmw_byte_order #(.WB(WORD_BYTES)) u_pack_data (
        .msb_first_i (msb_lat),
        .in_i        (payload[WW-1:0]),
        .out_o       (mod_data)
    );

    rmw_byte_order #(.WB(WORD_BYTES)) u_pack_mask (
        .msb_first_i (msb_lat),
        .in_i        (payload[PW-1:WW]),
        .out_o       (mod_mask)
    );

    rmw_byte_order #(.WB(WORD_BYTES)) u_unpack_orig (
        .msb_first_i (msb_lat),
        .in_i        (mod_orig),
        .out_o       (orig_bytes)
    );

    rmw_reply_gen #(.WB(WORD_BYTES)) u_reply (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (rep_start),
        .err_i       (err),
        .status_i    (status),
        .bytes_i     (orig_bytes),
        .rep_valid_o (rep_valid),
        .rep_data_o  (rep_data),
        .rep_last_o  (last_w)
    );

    assign rep_last = last_w;

endmodule

// File: tb/rmw_sequencer_test.sv
module rmw_sequencer_test;

    typedef logic [7:0] bq_t[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_msb_first = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_instr = 4'd0;
    logic [23:0] cmd_len = 24'd0;
    logic [31:0] cmd_addr = 32'd0;
    logic [63:0] cmd_payload = 64'd0;
    logic        bus_req, bus_stb, bus_we;
    logic        bus_gnt = 1'b0;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = 32'd0;
    logic        mod_req;
    logic [31:0] mod_orig, mod_data, mod_mask;
    logic        mod_ack = 1'b0;
    logic [31:0] mod_word = 32'd0;
    logic        rep_valid, rep_last;
    logic [7:0]  rep_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit run_chk = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rmw_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_instr(cmd_instr),
        .cmd_len(cmd_len), .cmd_addr(cmd_addr), .cmd_payload(cmd_payload),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .mod_req(mod_req), .mod_orig(mod_orig), .mod_data(mod_data), .mod_mask(mod_mask),
        .mod_ack(mod_ack), .mod_word(mod_word),
        .rep_valid(rep_valid), .rep_data(rep_data), .rep_last(rep_last)
    );

    task automatic chk(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // CRC-8, generator 0x07, bit 0 of each byte first (R11)
    function automatic logic [7:0] crc_of(input bq_t q, input int from, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            int b = int'(q[from + i]);
            for (int j = 0; j < 8; j++) begin
                int top = ((c >> 7) & 1) ^ ((b >> j) & 1);
                c = (c << 1) & 255;
                if (top != 0) c = c ^ 7;
            end
        end
        return 8'(c);
    endfunction

    function automatic bq_t mk_reply(input logic [7:0] st, input logic [31:0] w, input logic msb, input bit err);
        bq_t q;
        q.push_back(st);
        q.push_back(8'h00);
        q.push_back(8'h00);
        q.push_back(err ? 8'h00 : 8'h04);
        q.push_back(crc_of(q, 0, 4));
        if (!err) begin
            for (int k = 0; k < 4; k++) q.push_back(msb ? w[8*(3-k) +: 8] : w[8*k +: 8]);
            q.push_back(crc_of(q, 5, 4));
        end
        return q;
    endfunction

    function automatic logic [31:0] pack(input logic [63:0] pl, input int base, input logic msb);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) begin
            if (msb) w[8*(3-k) +: 8] = pl[8*(base+k) +: 8];
            else     w[8*k +: 8]     = pl[8*(base+k) +: 8];
        end
        return w;
    endfunction

    // Bus and modify responders
    int gnt_dly = 0, ack_dly = 0, mod_dly = 0;
    int gcnt = 0, acnt = 0, mcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0; bus_ack <= 1'b0; mod_ack <= 1'b0;
            gcnt <= 0; acnt <= 0; mcnt <= 0;
        end else begin
            if (bus_req && !mod_req) begin
                bus_gnt <= (gcnt >= gnt_dly);
                gcnt <= gcnt + 1;
            end else begin
                bus_gnt <= 1'b0; gcnt <= 0;
            end
            if (bus_stb && !bus_ack) begin
                bus_ack <= (acnt >= ack_dly);
                acnt <= acnt + 1;
            end else begin
                bus_ack <= 1'b0; acnt <= 0;
            end
            if (mod_req && !mod_ack) begin
                mod_ack <= (mcnt >= mod_dly);
                mcnt <= mcnt + 1;
            end else begin
                mod_ack <= 1'b0; mcnt <= 0;
            end
        end
    end

    // Reference model, updated at each rising edge from the inputs
    int          m_st = 0;
    int          m_pos = 0;
    bit          m_err = 1'b0;
    logic        m_msb = 1'b0;
    logic [31:0] m_addr = '0, m_orig = '0, m_new = '0;
    logic [63:0] m_pl = '0;
    bq_t         m_rep;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_rep.delete();
        end else begin
            case (m_st)
                0: if (cmd_valid) begin
                    m_msb = cfg_msb_first; m_addr = cmd_addr; m_pl = cmd_payload;
                    if (cmd_instr != 4'd7) begin
                        m_rep = mk_reply(8'h02, 32'd0, 1'b0, 1'b1); m_err = 1'b1; m_pos = 0; m_st = 6;
                    end else if (cmd_len != 24'd8) begin
                        m_rep = mk_reply(8'h05, 32'd0, 1'b0, 1'b1); m_err = 1'b1; m_pos = 0; m_st = 6;
                    end else begin
                        m_st = 1;
                    end
                end
                1: if (bus_gnt) m_st = 2;
                2: if (bus_ack) begin m_orig = bus_rdata; m_st = 3; end
                3: if (mod_ack) begin m_new = mod_word; m_st = 4; end
                4: if (bus_gnt) m_st = 5;
                5: if (bus_ack) begin
                    m_rep = mk_reply(8'h00, m_orig, m_msb, 1'b0); m_err = 1'b0; m_pos = 0; m_st = 6;
                end
                default: begin
                    void'(m_rep.pop_front());
                    m_pos++;
                    if (m_rep.size() == 0) m_st = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (run_chk) begin
            string rt;
            rt = m_err ? "R10" : "R9";
            chk("R12", "cmd_ready", cmd_ready, m_st == 0);
            chk("R8", "bus_req", bus_req, m_st >= 1 && m_st <= 5);
            chk("R5", "bus_stb", bus_stb, m_st == 2 || m_st == 5);
            chk("R7", "bus_we", bus_we, m_st == 5);
            if (m_st == 2 || m_st == 5) chk("R5", "bus_addr", bus_addr, m_addr);
            if (m_st == 5) chk("R7", "bus_wdata", bus_wdata, m_new);
            chk("R6", "mod_req", mod_req, m_st == 3);
            if (m_st == 3) begin
                chk("R6", "mod_orig", mod_orig, m_orig);
                chk("R4", "mod_data", mod_data, pack(m_pl, 0, m_msb));
                chk("R4", "mod_mask", mod_mask, pack(m_pl, 4, m_msb));
            end
            chk(rt, "rep_valid", rep_valid, m_st == 6);
            if (m_st == 6 && m_rep.size() > 0) begin
                chk((m_pos == 4 || m_pos == 9) ? "R11" : rt, "rep_data", rep_data, m_rep[0]);
                chk(rt, "rep_last", rep_last, m_rep.size() == 1);
            end
        end
    end

    // Reply capture and bus-request observation
    bq_t got;
    int  req_seen = 0;
    always @(negedge clk) begin
        if (rep_valid) got.push_back(rep_data);
        if (bus_req) req_seen++;
    end

    task automatic run_cmd(input logic [3:0] instr, input logic [23:0] len, input logic [31:0] addr,
                           input logic [63:0] pl, input logic msb, input logic [31:0] rd,
                           input int gd, input int ad, input int md);
        logic [31:0] dw, mw;
        bq_t         exp;
        bit          bad;
        string       tg;
        gnt_dly = gd; ack_dly = ad; mod_dly = md;
        dw = pack(pl, 0, msb);
        mw = pack(pl, 4, msb);
        bus_rdata = rd;
        mod_word  = (rd & ~mw) | (dw & mw);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        got.delete();
        req_seen = 0;
        cfg_msb_first = msb;
        cmd_instr = instr; cmd_len = len; cmd_addr = addr; cmd_payload = pl;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cfg_msb_first = ~msb;   // must not affect this command (R4)
        cmd_instr = 4'd0;
        while (!cmd_ready) @(negedge clk);
        bad = (instr != 4'd7) || (len != 24'd8);
        tg  = (instr != 4'd7) ? "R2" : (bad ? "R3" : "R9");
        exp = mk_reply((instr != 4'd7) ? 8'h02 : (bad ? 8'h05 : 8'h00), rd, msb, bad);
        chk(tg, "reply_len", got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk((i == 4 || i == 9) ? "R11" : tg, "reply_byte", got[i], exp[i]);
        if (bad) chk(tg, "no_bus_req_cycles", req_seen, 0);
        else     chk("R9", "orig_not_new", (got.size() > 5) ? got[5] : 8'hxx, msb ? rd[31:24] : rd[7:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset_cmd_ready", cmd_ready, 1'b1);
        chk("R1", "reset_bus_req", bus_req, 1'b0);
        chk("R1", "reset_bus_stb", bus_stb, 1'b0);
        chk("R1", "reset_mod_req", mod_req, 1'b0);
        chk("R1", "reset_rep_valid", rep_valid, 1'b0);
        rst_n = 1'b1;
        run_chk = 1'b1;
        @(negedge clk);
        chk("R1", "post_reset_ready", cmd_ready, 1'b1);

        run_cmd(4'b0111, 24'd8, 32'h1234_5678, 64'hF0F0_FF00_A1B2_C3D4, 1'b1, 32'hDEAD_BEEF, 0, 0, 0);
        run_cmd(4'b0111, 24'd8, 32'h0000_0040, 64'h0F00_FF0F_1122_3344, 1'b0, 32'h5566_7788, 2, 3, 1);
        run_cmd(4'b0111, 24'd8, 32'hA5A5_A5A4, 64'hFFFF_FFFF_0102_0304, 1'b1, 32'hCAFE_F00D, 4, 1, 5);
        run_cmd(4'b0011, 24'd8, 32'h0000_1000, 64'h0123_4567_89AB_CDEF, 1'b1, 32'h0, 0, 0, 0);
        run_cmd(4'b0111, 24'd4, 32'h0000_2000, 64'h0123_4567_89AB_CDEF, 1'b0, 32'h0, 0, 0, 0);
        run_cmd(4'b0111, 24'd16, 32'h0000_3000, 64'h0123_4567_89AB_CDEF, 1'b1, 32'h0, 0, 0, 0);
        run_cmd(4'b0111, 24'd8, 32'h7FFF_FFFC, 64'h0000_0000_9988_7766, 1'b0, 32'h1357_9BDF, 1, 0, 2);
        run_cmd(4'b0111, 24'd8, 32'h0000_0000, 64'h00FF_00FF_FFFF_FFFF, 1'b1, 32'h0000_0000, 0, 2, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule